// File: doc/BRIEF.md
# Word-Controlled SPI Master

This block is a serial peripheral interface master in which every transmit word carries its own control bits. A single holding register takes up to 16 data bits together with four flags. The flags set the select level for that word and say whether the select line drops after it. They also say whether a frame gap follows the word and whether its received data is kept. The shift engine drives SCK (idle low), MOSI and an active-low select. It samples MISO and delivers each kept word to a receive holding register.

Software writes through a small register port with four addresses. Address 0 writes data and control together. Address 1 writes data only, reusing the control flags last written. Address 2 writes the control flags only. Address 3 sets the word length (`len_m1`, bits [3:0], length = value + 1), the transfer delay (bits [7:4]) and the frame delay (bits [11:8]). On addresses 0 and 1, data sits in bits [15:0]. On addresses 0 and 2 the control flags sit in bits [19:16]. Bit 16 is `sel_off`: 0 asserts select, 1 keeps it high. Bit 17 is end-of-transfer, bit 18 is end-of-frame and bit 19 is receive-ignore. Words longer than 16 bits are sent as consecutive entries with the transfer kept open, and end-of-frame is set only on the last entry.

Top module: `spi_wordctl_master`

## Requirements
- R1: After reset `ssel_n`=1, `sck`=0, `tx_ready`=1, `rx_valid`=0 and `tx_err`=0, and the word length is 16 bits.
- R2: A word of `len_m1`+1 bits (1 to 16) is shifted MSB first. MOSI changes only while SCK falls and is steady at each rising SCK edge. Each SCK half-period is one clock cycle.
- R3: With receive-ignore clear, the MISO bits of the word (MSB first, right-aligned, upper bits zero) appear on `rx_data` with `rx_valid`=1. A one-cycle `rx_rd` clears `rx_valid`.
- R4: A word with `sel_off`=1 is clocked out with `ssel_n` held high for the whole word.
- R5: With end-of-transfer set, `ssel_n` rises after the word's last bit and stays high for transfer delay + 1 clock cycles before a word that is already queued.
- R6: With end-of-transfer clear, `ssel_n` stays low between that word and the next.
- R7: With end-of-frame set, SCK stays low for frame delay + 3 cycles between the last rising edge of the word and the first rising edge of a queued next word. With end-of-frame clear, or a frame delay of zero, the gap is 3 cycles.
- R8: With receive-ignore set, the word shifts even while `rx_valid`=1, and `rx_data` and `rx_valid` are left unchanged.
- R9: With receive-ignore clear, a new word does not start while `rx_valid`=1. SCK stays low, the select level is kept and the queued word stays in the holding register (`tx_ready`=0).
- R10: A data-only write (address 1) uses the control flags from the last address-0 or address-2 write. An address-2 write changes no word that is already queued.
- R11: `tx_ready` is 1 when the holding register is empty. A data write while it is full, and not being drained in that cycle, is ignored and sets the sticky `tx_err`. A write in the same cycle that the engine drains the register is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 data+control, 1 data, 2 control, 3 config) |
| wr_data | input | 20 | Register write data |
| rx_rd | input | 1 | Pop the receive holding register |
| rx_data | output | 16 | Received word |
| rx_valid | output | 1 | Receive holding register full |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_err | output | 1 | Sticky rejected-write flag |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssel_n | output | 1 | Active-low slave select |

## Verification
A software write to the transmit holding register can land in the same cycle in which the shift engine drains that register into its shifter. The bench provokes this with three writes on consecutive cycles from idle. The second write meets the drain cycle of the first and must be accepted. The third finds the register full while the engine is busy and must be rejected. The outcome is judged at the pins: both accepted words must appear on MOSI in order, the third word must not appear, and `tx_err` must be 0 before the third write and 1 after it.

// File: rtl/spiwc_pkg.sv
package spiwc_pkg;
  localparam int CTL_LSB = 16;
  localparam int CTLW    = 4;
  localparam int WRW     = CTL_LSB + CTLW;

  typedef enum logic [1:0] {
    A_DATCTL = 2'd0,
    A_DATA   = 2'd1,
    A_CTL    = 2'd2,
    A_CFG    = 2'd3
  } addr_e;

  // packed MSB first: sel_off lands on the lowest bit
  typedef struct packed {
    logic rx_ign;
    logic eof;
    logic eot;
    logic sel_off;
  } ctl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_HI, S_LO, S_LAST, S_TDLY, S_FDLY
  } st_e;
endpackage

// File: rtl/spiwc_regs.sv
module spiwc_regs
  import spiwc_pkg::*;
#(
  parameter int DW   = 16,
  parameter int LENW = 4,
  parameter int DLYW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [WRW-1:0]  wr_data,
  input  logic            take,
  output logic            tx_full,
  output logic [DW-1:0]   tx_data,
  output ctl_t            tx_ctl,
  output logic [LENW-1:0] len_m1,
  output logic [DLYW-1:0] xdly,
  output logic [DLYW-1:0] fdly,
  output logic            tx_err
);
  localparam int CFGW = LENW + 2*DLYW;

  logic            full_q, full_d;
  logic [DW-1:0]   data_q, data_d;
  ctl_t            ent_q, ent_d, last_q, last_d;
  logic [LENW-1:0] len_q, len_d;
  logic [DLYW-1:0] xd_q, xd_d, fd_q, fd_d;
  logic            err_q, err_d;
  ctl_t            wr_ctl;
  addr_e           addr;
  logic            cfg_unused;

  assign wr_ctl     = ctl_t'(wr_data[CTL_LSB +: CTLW]);
  assign addr       = addr_e'(wr_addr);
  assign cfg_unused = ^wr_data[WRW-1:CFGW];

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    ent_d  = ent_q;
    last_d = last_q;
    len_d  = len_q;
    xd_d   = xd_q;
    fd_d   = fd_q;
    err_d  = err_q;
    if (take) full_d = 1'b0;
    if (wr_en) begin
      unique case (addr)
        A_DATCTL, A_DATA: begin
          if (!full_q || take) begin
            full_d = 1'b1;
            data_d = wr_data[DW-1:0];
            if (addr == A_DATCTL) begin
              ent_d  = wr_ctl;
              last_d = wr_ctl;
            end else begin
              ent_d  = last_q;
            end
          end else begin
            err_d = 1'b1;
          end
        end
        A_CTL: last_d = wr_ctl;
        A_CFG: begin
          len_d = wr_data[LENW-1:0];
          xd_d  = wr_data[LENW +: DLYW];
          fd_d  = wr_data[LENW+DLYW +: DLYW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      ent_q  <= '0;
      last_q <= '0;
      len_q  <= '1;
      xd_q   <= '0;
      fd_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
      ent_q  <= ent_d;
      last_q <= last_d;
      len_q  <= len_d;
      xd_q   <= xd_d;
      fd_q   <= fd_d;
      err_q  <= err_d;
    end
  end

  assign tx_full = full_q;
  assign tx_data = data_q;
  assign tx_ctl  = ent_q;
  assign len_m1  = len_q;
  assign xdly    = xd_q;
  assign fdly    = fd_q;
  assign tx_err  = err_q;

  // R11: the error flag never clears once set
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R11: a write into a full, undrained register leaves the entry as it was
  a_r11_reject_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[1] && full_q && !take) |=> (err_q && full_q && $stable(data_q)));
endmodule

// File: rtl/spiwc_engine.sv
module spiwc_engine
  import spiwc_pkg::*;
#(
  parameter int DW   = 16,
  parameter int LENW = 4,
  parameter int DLYW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_full,
  input  logic [DW-1:0]   tx_data,
  input  ctl_t            tx_ctl,
  input  logic [LENW-1:0] len_m1,
  input  logic [DLYW-1:0] xdly,
  input  logic [DLYW-1:0] fdly,
  input  logic            rx_full,
  input  logic            miso,
  output logic            take,
  output logic            rx_push,
  output logic [DW-1:0]   rx_word,
  output logic            sck,
  output logic            mosi,
  output logic            sel
);
  localparam int CNTW = (LENW > DLYW) ? LENW : DLYW;

  st_e             st_q, st_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [DW-1:0]   sh_q, sh_d, rsh_q, rsh_d;
  ctl_t            ctl_q, ctl_d;
  logic [LENW-1:0] len_q, len_d;
  logic            sel_q, sel_d;
  logic            sck_q, sck_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rsh_d   = rsh_q;
    ctl_d   = ctl_q;
    len_d   = len_q;
    sel_d   = sel_q;
    take    = 1'b0;
    rx_push = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (tx_full && (tx_ctl.rx_ign || !rx_full)) begin
          take  = 1'b1;
          sh_d  = tx_data;
          rsh_d = '0;
          ctl_d = tx_ctl;
          len_d = len_m1;
          cnt_d = CNTW'(len_m1);
          sel_d = !tx_ctl.sel_off;
          st_d  = S_SETUP;
        end
      end
      S_SETUP: st_d = S_HI;
      S_HI: begin
        rsh_d = {rsh_q[DW-2:0], miso};
        if (cnt_q == '0) begin
          st_d = S_LAST;
        end else begin
          sh_d  = {sh_q[DW-2:0], 1'b0};
          cnt_d = cnt_q - 1'b1;
          st_d  = S_LO;
        end
      end
      S_LO: st_d = S_HI;
      S_LAST: begin
        rx_push = !ctl_q.rx_ign;
        if (ctl_q.eot) sel_d = 1'b0;
        if (ctl_q.eot && xdly != '0) begin
          st_d  = S_TDLY;
          cnt_d = CNTW'(xdly);
        end else if (ctl_q.eof && fdly != '0) begin
          st_d  = S_FDLY;
          cnt_d = CNTW'(fdly);
        end else begin
          st_d  = S_IDLE;
        end
      end
      S_TDLY: begin
        if (cnt_q == CNTW'(1)) begin
          if (ctl_q.eof && fdly != '0) begin
            st_d  = S_FDLY;
            cnt_d = CNTW'(fdly);
          end else begin
            st_d  = S_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      S_FDLY: begin
        if (cnt_q == CNTW'(1)) st_d = S_IDLE;
        else                   cnt_d = cnt_q - 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
    sck_d = (st_d == S_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      rsh_q <= '0;
      ctl_q <= '0;
      len_q <= '0;
      sel_q <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      rsh_q <= rsh_d;
      ctl_q <= ctl_d;
      len_q <= len_d;
      sel_q <= sel_d;
      sck_q <= sck_d;
    end
  end

  assign sck     = sck_q;
  assign mosi    = sh_q[len_q];
  assign sel     = sel_q;
  assign rx_word = rsh_q;

  // R2: data out is already settled when SCK rises
  a_r2_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |-> $stable(mosi));
  // R4: select only turns on as a word is loaded
  a_r4_sel_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> (st_q == S_SETUP));
  // R5: end-of-transfer drops select after the last bit
  a_r5_eot_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_LAST && ctl_q.eot) |=> !sel_q);
  // R6: without end-of-transfer the select level survives the word end
  a_r6_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_LAST && !ctl_q.eot) |=> (sel_q == $past(sel_q)));
  // R9: a kept-data word waits for the receive register to empty
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && rx_full && !tx_ctl.rx_ign) |=> (st_q == S_IDLE && !sck_q));
endmodule

// File: rtl/spiwc_rxhold.sv
module spiwc_rxhold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] word,
  input  logic          rd,
  output logic [DW-1:0] data,
  output logic          valid
);
  logic [DW-1:0] data_q, data_d;
  logic          valid_q, valid_d;

  always_comb begin
    data_d  = data_q;
    valid_d = valid_q;
    if (rd)   valid_d = 1'b0;
    if (push) begin
      valid_d = 1'b1;
      data_d  = word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign data  = data_q;
  assign valid = valid_q;

  // R3: the engine never delivers into a full register
  a_r3_push_empty: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !valid_q);
  // R3: a read with no new word leaves the register empty
  a_r3_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !push) |=> !valid_q);
endmodule

// File: rtl/spi_wordctl_master.sv
module spi_wordctl_master
  import spiwc_pkg::*;
#(
  parameter int DW   = 16,
  parameter int LENW = 4,
  parameter int DLYW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [WRW-1:0] wr_data,
  input  logic           rx_rd,
  output logic [DW-1:0]  rx_data,
  output logic           rx_valid,
  output logic           tx_ready,
  output logic           tx_err,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic           ssel_n
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            take, tx_full, rx_push, sel;
  logic [DW-1:0]   tx_data, rx_word;
  ctl_t            tx_ctl;
  logic [LENW-1:0] len_m1;
  logic [DLYW-1:0] xdly, fdly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  spiwc_regs #(.DW(DW), .LENW(LENW), .DLYW(DLYW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .take(take), .tx_full(tx_full), .tx_data(tx_data),
    .tx_ctl(tx_ctl), .len_m1(len_m1), .xdly(xdly), .fdly(fdly), .tx_err(tx_err)
  );

  spiwc_engine #(.DW(DW), .LENW(LENW), .DLYW(DLYW)) u_engine (
    .clk(clk), .rst_n(rst_int_n), .tx_full(tx_full), .tx_data(tx_data),
    .tx_ctl(tx_ctl), .len_m1(len_m1), .xdly(xdly), .fdly(fdly),
    .rx_full(rx_valid), .miso(miso), .take(take), .rx_push(rx_push),
    .rx_word(rx_word), .sck(sck), .mosi(mosi), .sel(sel)
  );

  spiwc_rxhold #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .push(rx_push), .word(rx_word),
    .rd(rx_rd), .data(rx_data), .valid(rx_valid)
  );

  assign tx_ready = !tx_full;
  assign ssel_n   = !sel;
endmodule

// File: tb/test_spi_wordctl_master.sv
module test_spi_wordctl_master;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;
  localparam int NVEC       = 5;
  // {len_m1, tx data, slave pattern}
  localparam logic [35:0] VECS [NVEC] = '{
    {4'd15, 16'hA5C3, 16'h3C5A},
    {4'd7,  16'h0081, 16'h00F0},
    {4'd0,  16'h0001, 16'h0000},
    {4'd0,  16'h0000, 16'h0001},
    {4'd11, 16'h0ABC, 16'h0F0F}
  };

  logic        clk, rst_n, wr_en, rx_rd, miso;
  logic [1:0]  wr_addr;
  logic [19:0] wr_data;
  logic [15:0] rx_data;
  logic        rx_valid, tx_ready, tx_err, sck, mosi, ssel_n;

  int nchk = 0, nfail = 0, cyc = 0;
  int falls = 0, base_f = 0;
  int capn = 0, hi_rises = 0;
  logic [31:0] cap = '0;
  int lowrun = 0, rises = 0, shrun = 0, last_shigh = 0, sel_falls = 0, sel_low = 0;
  int glog [64];
  logic prev_sck = 1'b0, prev_ssel = 1'b1;
  logic [15:0] slv_pat = '0;
  logic [3:0]  sidx;

  spi_wordctl_master i_spi_wordctl_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid), .tx_ready(tx_ready),
    .tx_err(tx_err), .sck(sck), .mosi(mosi), .miso(miso), .ssel_n(ssel_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // slave model: next bit presented after each falling SCK
  assign sidx = 4'(falls - base_f);
  assign miso = slv_pat[4'd15 - sidx];
  always @(negedge sck) falls <= falls + 1;

  always @(posedge sck) begin
    if (!ssel_n) begin
      cap  <= {cap[30:0], mosi};
      capn <= capn + 1;
    end else begin
      hi_rises <= hi_rises + 1;
    end
  end

  always @(negedge clk) begin
    if (sck) begin
      if (!prev_sck) begin
        glog[rises % 64] = lowrun;
        rises = rises + 1;
      end
      lowrun = 0;
    end else begin
      lowrun = lowrun + 1;
    end
    prev_sck = sck;
    if (ssel_n) begin
      shrun = shrun + 1;
    end else begin
      sel_low = sel_low + 1;
      if (prev_ssel) begin
        last_shigh = shrun;
        sel_falls  = sel_falls + 1;
      end
      shrun = 0;
    end
    prev_ssel = ssel_n;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      $display("FAIL watchdog act=%0d exp=<%0d cycles", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", nchk - nfail, nchk + 1);
      $finish;
    end
  end

  function automatic logic [3:0] ctl(input bit sel_off, eot, eof, rxign);
    return {rxign, eof, eot, sel_off};
  endfunction

  function automatic logic [31:0] msk(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [19:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_q(input logic [1:0] a, input logic [19:0] d);
    while (!tx_ready) @(negedge clk);
    wr(a, d);
  endtask

  task automatic cfg(input logic [3:0] l, input logic [3:0] x, input logic [3:0] f);
    wr(2'd3, {8'h00, f, x, l});
  endtask

  task automatic rd();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic wait_done();
    int q = 0;
    while (q < 40) begin
      @(negedge clk);
      if (!sck && ssel_n && tx_ready) q++;
      else q = 0;
    end
  endtask

  initial begin
    int bc, bs, br, bl;
    rst_n = 1'b0; wr_en = 1'b0; rx_rd = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 ssel_n", ssel_n, 1); chk("R1 sck", sck, 0); chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_valid", rx_valid, 0); chk("R1 tx_err", tx_err, 0);
    // R1: default length is 16 bits
    bc = capn;
    wr(2'd0, {ctl(0, 1, 0, 1), 16'h8001});
    wait_done();
    chk("R1 default length", capn - bc, 16);

    // R2/R3: vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] l; logic [15:0] d, p; int n;
      {l, d, p} = VECS[v];
      n = int'(l) + 1;
      cfg(l, 4'd0, 4'd0);
      slv_pat = p << (15 - int'(l));
      base_f = falls; bc = capn;
      wr(2'd0, {ctl(0, 1, 0, 0), d});
      wait_done();
      chk("R2 bit count", capn - bc, n);
      chk("R2 mosi word", cap & msk(n), {16'h0, d} & msk(n));
      chk("R3 rx_valid set", rx_valid, 1);
      chk("R3 rx_data", {16'h0, rx_data}, {16'h0, p} & msk(n));
      rd();
      chk("R3 rx_valid cleared", rx_valid, 0);
    end

    // R4: select held off
    cfg(4'd7, 4'd0, 4'd0);
    br = hi_rises; bl = sel_low;
    wr(2'd0, {ctl(1, 1, 0, 1), 16'h005A});
    wait_done();
    chk("R4 clocks with select off", hi_rises - br, 8);
    chk("R4 select never low", sel_low - bl, 0);

    // R6/R10: control write, then data-only words
    bs = sel_falls; bc = capn;
    wr(2'd2, {ctl(0, 0, 0, 1), 16'h0});
    wr_q(2'd1, 20'h00011);
    wr_q(2'd1, 20'h00022);
    wr(2'd2, {ctl(0, 1, 0, 1), 16'h0});
    wr_q(2'd1, 20'h00033);
    wait_done();
    chk("R6 one continuous select", sel_falls - bs, 1);
    chk("R10 bits sent", capn - bc, 24);
    chk("R10 data order", cap & msk(24), 32'h112233);

    // R5: transfer delay
    cfg(4'd3, 4'd5, 4'd0);
    wr(2'd0, {ctl(0, 1, 0, 1), 16'h1});
    wr_q(2'd0, {ctl(0, 1, 0, 1), 16'h2});
    wait_done();
    chk("R5 select high run, delay 5", last_shigh, 6);
    cfg(4'd3, 4'd0, 4'd0);
    wr(2'd0, {ctl(0, 1, 0, 1), 16'h1});
    wr_q(2'd0, {ctl(0, 1, 0, 1), 16'h2});
    wait_done();
    chk("R5 select high run, delay 0", last_shigh, 1);

    // R7: frame delay
    cfg(4'd3, 4'd0, 4'd4);
    br = rises;
    wr(2'd0, {ctl(0, 0, 1, 1), 16'h3});
    wr_q(2'd0, {ctl(0, 1, 0, 1), 16'h4});
    wait_done();
    chk("R7 gap with end-of-frame", glog[(br + 4) % 64], 7);
    br = rises;
    wr(2'd0, {ctl(0, 0, 0, 1), 16'h3});
    wr_q(2'd0, {ctl(0, 1, 0, 1), 16'h4});
    wait_done();
    chk("R7 gap without end-of-frame", glog[(br + 4) % 64], 3);

    // R9: stall while receive register full
    cfg(4'd3, 4'd0, 4'd0);
    slv_pat = 16'hA500; base_f = falls; bc = capn;
    wr(2'd0, {ctl(0, 0, 0, 0), 16'h3});
    wr_q(2'd0, {ctl(0, 1, 0, 0), 16'hC});
    repeat (60) @(negedge clk);
    chk("R9 select held", ssel_n, 0);
    chk("R9 word still queued", tx_ready, 0);
    chk("R9 no clocking", capn - bc, 4);
    chk("R3 first word", {16'h0, rx_data}, 32'hA);
    rd();
    wait_done();
    chk("R9 resumed", capn - bc, 8);
    chk("R6 joined bits", cap & msk(8), 32'h3C);
    chk("R3 second word", {16'h0, rx_data}, 32'h5);

    // R8: ignored word shifts past a full receive register
    slv_pat = 16'hF000; base_f = falls; bc = capn;
    wr(2'd0, {ctl(0, 1, 0, 1), 16'h9});
    wait_done();
    chk("R8 shifted", cap & msk(4), 32'h9);
    chk("R8 rx_data untouched", {16'h0, rx_data}, 32'h5);
    chk("R8 rx_valid untouched", rx_valid, 1);
    rd();
    chk("R8 rx empty after read", rx_valid, 0);

    // R11: write in drain cycle accepted, write while busy rejected
    cfg(4'd15, 4'd0, 4'd0);
    bc = capn;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = {ctl(0, 0, 0, 1), 16'hBEEF};
    @(negedge clk);
    wr_data = {ctl(0, 1, 0, 1), 16'h1234};
    @(negedge clk);
    chk("R11 no error on drain-cycle write", tx_err, 0);
    chk("R11 holding full", tx_ready, 0);
    wr_data = {ctl(0, 1, 0, 1), 16'hDEAD};
    @(negedge clk);
    wr_en = 1'b0;
    chk("R11 error on full write", tx_err, 1);
    wait_done();
    chk("R11 two words sent", capn - bc, 32);
    chk("R11 words on wire", cap, 32'hBEEF1234);
    chk("R11 error sticky", tx_err, 1);
    chk("R11 ready when empty", tx_ready, 1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule